// File: doc/BRIEF.md
# ATM Connection Address Translator

This block turns the routing fields of an incoming ATM cell header into a local connection index. It keeps separate tables for each ingress port. A cell arrives with its port number, VPI and VCI under a valid/ready handshake. Two cycles later the block returns a connection index, a flag telling whether the cell was switched as a whole virtual path or as a single virtual channel, and a miss indication.

For each port there is one path-mode bit per VPI value. When that bit is set, the whole VPI is the key into a 256-entry path table. When it is clear, the cell is treated as a channel connection. Its key is then built from the two low VPI bits followed by the eight low VCI bits, and it indexes a 1024-entry channel table. A channel header with a VPI above 3, or a VCI of 0 or above 255, has no valid channel key. Such a cell is reported as an out-of-range miss and is never aliased onto a table entry.

A host write port programs path entries, channel entries and path-mode bits, one per cycle. A lookup presented in the same cycle as a write sees the contents from before that write.

Top module: `atm_xlate`

## Requirements
- R1: With the path-mode bit set for (port, VPI), the lookup reads path-table entry VPI[7:0]. The VCI is ignored, `out_is_vp` is 1 and `out_range_err` is 0.
- R2: With the path-mode bit clear, the lookup reads channel-table entry {VPI[1:0], VCI[7:0]}, with VPI bits in address bits 9:8. `out_is_vp` is 0.
- R3: A channel-mode cell with VPI greater than 3 gives `out_miss`=1, `out_range_err`=1 and `out_idx`=0, even when the entry its low bits alias onto is valid.
- R4: A channel-mode cell with VCI equal to 0 or greater than 255 gives `out_miss`=1, `out_range_err`=1 and `out_idx`=0, even when the aliased entry is valid.
- R5: Each port has its own path table, channel table and path-mode bits. A write to one port does not change lookups on another.
- R6: A lookup that reaches an entry whose valid bit is 0 (all entries reset invalid) gives `out_miss`=1 and `out_idx`=0. For an in-range cell, `out_range_err`=0.
- R7: The host write with `host_tbl`=2 sets or clears the path-mode bit at `host_addr[7:0]` from `host_vld`. This bit alone selects between path and channel handling. All path-mode bits are 0 after reset.
- R8: A cell accepted at clock edge k (`in_valid` and `in_ready` high) appears with `out_valid`=1 after edge k+1 when the output is not stalled.
- R9: While `out_valid`=1 and `out_ready`=0, every output holds and `in_ready`=0. No accepted cell is lost or reordered.
- R10: A host write (`host_tbl` 0 = path entry, 1 = channel entry) updates one entry on one edge. A lookup presented in that same cycle returns the entry's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Cell header valid |
| in_ready | output | 1 | Block can accept a header |
| in_port | input | PORT_W | Ingress port number |
| in_vpi | input | 8 | Virtual path identifier |
| in_vci | input | 16 | Virtual channel identifier |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |
| out_idx | output | IDX_W | Connection index, 0 on miss |
| out_is_vp | output | 1 | Cell was handled as a path connection |
| out_miss | output | 1 | No valid connection found |
| out_range_err | output | 1 | Channel header outside the supported key range |
| host_we | input | 1 | Host write strobe |
| host_port | input | PORT_W | Port whose tables are written |
| host_tbl | input | 2 | 0 path entry, 1 channel entry, 2 path-mode bit |
| host_addr | input | 10 | Entry address (path and mode use bits 7:0) |
| host_vld | input | 1 | Valid bit or path-mode bit value |
| host_idx | input | IDX_W | Connection index to store |

## Verification
The bench builds the block with two ports and 8-bit indices. With two ports, the same header can be programmed differently on each side, which exercises table separation. The full 256-entry path table and 1024-entry channel table per port are kept, so the real alias points sit inside the address space a stray key could hit: VPI 5 onto VPI 1, VCI 0x105 onto VCI 5, and VCI 0. A held output with a second header queued behind it exercises the stall path.

// File: rtl/atm_xlate_pkg.sv
package atm_xlate_pkg;
  localparam int VPI_W      = 8;
  localparam int VCI_W      = 16;
  localparam int VC_VPI_BITS = 2;
  localparam int VC_VCI_BITS = 8;
  localparam int VP_ADDR_W  = VPI_W;
  localparam int VC_ADDR_W  = VC_VPI_BITS + VC_VCI_BITS;

  typedef enum logic [1:0] {
    TBL_PATH_ENT = 2'd0,
    TBL_CHAN_ENT = 2'd1,
    TBL_PATH_BIT = 2'd2
  } host_tbl_e;
endpackage

// File: rtl/atm_key_form.sv
module atm_key_form
  import atm_xlate_pkg::*;
(
  input  logic [VPI_W-1:0]     vpi,
  input  logic [VCI_W-1:0]     vci,
  input  logic                 path_mode,
  output logic [VP_ADDR_W-1:0] vp_addr,
  output logic [VC_ADDR_W-1:0] vc_addr,
  output logic                 range_bad
);
  logic vpi_high;
  logic vci_high;
  logic vci_zero;

  always_comb begin
    vp_addr   = vpi;
    vc_addr   = {vpi[VC_VPI_BITS-1:0], vci[VC_VCI_BITS-1:0]};
    vpi_high  = |vpi[VPI_W-1:VC_VPI_BITS];
    vci_high  = |vci[VCI_W-1:VC_VCI_BITS];
    vci_zero  = (vci == '0);
    range_bad = !path_mode && (vpi_high || vci_high || vci_zero);
  end
endmodule

// File: rtl/atm_xlate_bank.sv
module atm_xlate_bank #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic              wvld,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic              rd_vld,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  vld_d;
  logic [DATA_W-1:0] mem [DEPTH];

  always_comb begin
    vld_d = vld_q;
    if (we) vld_d[waddr] = wvld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (we) vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else if (re) begin
      rd_vld  <= vld_q[raddr];
      rd_data <= mem[raddr];
    end
  end
endmodule

// File: rtl/atm_xlate.sv
module atm_xlate
  import atm_xlate_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int IDX_W     = 8,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PORT_W-1:0] in_port,
  input  logic [7:0]        in_vpi,
  input  logic [15:0]       in_vci,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  out_idx,
  output logic              out_is_vp,
  output logic              out_miss,
  output logic              out_range_err,
  input  logic              host_we,
  input  logic [PORT_W-1:0] host_port,
  input  logic [1:0]        host_tbl,
  input  logic [9:0]        host_addr,
  input  logic              host_vld,
  input  logic [IDX_W-1:0]  host_idx
);
  localparam int MODE_DEPTH = 1 << VP_ADDR_W;

  host_tbl_e tbl_sel;
  logic      adv;

  logic [MODE_DEPTH-1:0] mode_q [NUM_PORTS];
  logic                  in_path_mode;
  logic [VP_ADDR_W-1:0]  vp_addr;
  logic [VC_ADDR_W-1:0]  vc_addr;
  logic                  range_bad;

  logic              vp_rvld  [NUM_PORTS];
  logic [IDX_W-1:0]  vp_rdata [NUM_PORTS];
  logic              vc_rvld  [NUM_PORTS];
  logic [IDX_W-1:0]  vc_rdata [NUM_PORTS];

  logic              s1_valid_q, s1_valid_d;
  logic [PORT_W-1:0] s1_port_q,  s1_port_d;
  logic              s1_path_q,  s1_path_d;
  logic              s1_bad_q,   s1_bad_d;

  logic              ent_vld;
  logic [IDX_W-1:0]  ent_idx;
  logic              o_valid_d, o_is_vp_d, o_miss_d, o_err_d;
  logic [IDX_W-1:0]  o_idx_d;

  assign tbl_sel  = host_tbl_e'(host_tbl);
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  assign in_path_mode = mode_q[in_port][in_vpi];

  atm_key_form u_key (
    .vpi       (in_vpi),
    .vci       (in_vci),
    .path_mode (in_path_mode),
    .vp_addr   (vp_addr),
    .vc_addr   (vc_addr),
    .range_bad (range_bad)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit_port;
    logic we_vp, we_vc, we_mode;
    logic [MODE_DEPTH-1:0] mode_d;

    assign hit_port = host_we && (host_port == PORT_W'(p));
    assign we_vp    = hit_port && (tbl_sel == TBL_PATH_ENT);
    assign we_vc    = hit_port && (tbl_sel == TBL_CHAN_ENT);
    assign we_mode  = hit_port && (tbl_sel == TBL_PATH_BIT);

    always_comb begin
      mode_d = mode_q[p];
      mode_d[host_addr[VP_ADDR_W-1:0]] = host_vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q[p] <= '0;
      else if (we_mode) mode_q[p] <= mode_d;
    end

    atm_xlate_bank #(.ADDR_W(VP_ADDR_W), .DATA_W(IDX_W)) u_vp (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (we_vp),
      .waddr   (host_addr[VP_ADDR_W-1:0]),
      .wvld    (host_vld),
      .wdata   (host_idx),
      .re      (adv),
      .raddr   (vp_addr),
      .rd_vld  (vp_rvld[p]),
      .rd_data (vp_rdata[p])
    );

    atm_xlate_bank #(.ADDR_W(VC_ADDR_W), .DATA_W(IDX_W)) u_vc (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (we_vc),
      .waddr   (host_addr[VC_ADDR_W-1:0]),
      .wvld    (host_vld),
      .wdata   (host_idx),
      .re      (adv),
      .raddr   (vc_addr),
      .rd_vld  (vc_rvld[p]),
      .rd_data (vc_rdata[p])
    );
  end

  always_comb begin
    s1_valid_d = in_valid;
    s1_port_d  = in_port;
    s1_path_d  = in_path_mode;
    s1_bad_d   = range_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_port_q  <= '0;
      s1_path_q  <= 1'b0;
      s1_bad_q   <= 1'b0;
    end else if (adv) begin
      s1_valid_q <= s1_valid_d;
      s1_port_q  <= s1_port_d;
      s1_path_q  <= s1_path_d;
      s1_bad_q   <= s1_bad_d;
    end
  end

  always_comb begin
    ent_vld   = s1_path_q ? vp_rvld[s1_port_q]  : vc_rvld[s1_port_q];
    ent_idx   = s1_path_q ? vp_rdata[s1_port_q] : vc_rdata[s1_port_q];
    o_valid_d = s1_valid_q;
    o_is_vp_d = s1_path_q;
    o_err_d   = s1_bad_q;
    o_miss_d  = s1_bad_q || !ent_vld;
    o_idx_d   = o_miss_d ? '0 : ent_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_idx       <= '0;
      out_is_vp     <= 1'b0;
      out_miss      <= 1'b0;
      out_range_err <= 1'b0;
    end else if (adv) begin
      out_valid     <= o_valid_d;
      out_idx       <= o_idx_d;
      out_is_vp     <= o_is_vp_d;
      out_miss      <= o_miss_d;
      out_range_err <= o_err_d;
    end
  end
endmodule

// File: rtl/atm_xlate_chk.sv
module atm_xlate_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [IDX_W-1:0] out_idx,
  input logic             out_is_vp,
  input logic             out_miss,
  input logic             out_range_err
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_idx) && $stable(out_miss)
                                 && $stable(out_is_vp) && $stable(out_range_err));

  p_stall_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> ##1 out_valid);

  p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_miss |-> out_idx == '0);

  p_range_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_range_err |-> out_miss && !out_is_vp);

  p_path_no_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_vp |-> !out_range_err);
endmodule

bind atm_xlate atm_xlate_chk #(.IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_idx       (out_idx),
  .out_is_vp     (out_is_vp),
  .out_miss      (out_miss),
  .out_range_err (out_range_err)
);

// File: tb/atm_xlate_tb.sv
module atm_xlate_tb;
  localparam int NP = 2;
  localparam int IW = 8;
  localparam int PW = 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_ready;
  logic [PW-1:0] in_port;
  logic [7:0]    in_vpi;
  logic [15:0]   in_vci;
  logic          out_valid, out_ready;
  logic [IW-1:0] out_idx;
  logic          out_is_vp, out_miss, out_range_err;
  logic          host_we;
  logic [PW-1:0] host_port;
  logic [1:0]    host_tbl;
  logic [9:0]    host_addr;
  logic          host_vld;
  logic [IW-1:0] host_idx;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  atm_xlate #(.NUM_PORTS(NP), .IDX_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_port(in_port),
    .in_vpi(in_vpi), .in_vci(in_vci),
    .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx),
    .out_is_vp(out_is_vp), .out_miss(out_miss), .out_range_err(out_range_err),
    .host_we(host_we), .host_port(host_port), .host_tbl(host_tbl),
    .host_addr(host_addr), .host_vld(host_vld), .host_idx(host_idx)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hwr(int port, int tbl, int addr, bit vld, int idx);
    @(negedge clk);
    host_we = 1'b1; host_port = PW'(port); host_tbl = 2'(tbl);
    host_addr = 10'(addr); host_vld = vld; host_idx = IW'(idx);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic look(string req, int port, int vpi, int vci,
                      int e_idx, bit e_vp, bit e_miss, bit e_err);
    @(negedge clk);
    in_valid = 1'b1; in_port = PW'(port); in_vpi = 8'(vpi); in_vci = 16'(vci);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R8 not early"}, int'(out_valid), 0);
    @(negedge clk);
    chk({req, " R8 valid"}, int'(out_valid), 1);
    chk({req, " idx"}, int'(out_idx), e_idx);
    chk({req, " is_vp"}, int'(out_is_vp), int'(e_vp));
    chk({req, " miss"}, int'(out_miss), int'(e_miss));
    chk({req, " range_err"}, int'(out_range_err), int'(e_err));
  endtask

  task automatic t_reset();
    chk("R8 reset out_valid", int'(out_valid), 0);
    chk("R9 reset in_ready", int'(in_ready), 1);
    look("R6 R7 reset state", 0, 1, 7, 0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_path();
    hwr(0, 2, 8'h9A, 1'b1, 0);
    hwr(0, 0, 8'h9A, 1'b1, 8'h55);
    hwr(0, 2, 8'hFF, 1'b1, 0);
    hwr(0, 0, 8'hFF, 1'b1, 8'hA1);
    look("R1 path 9A", 0, 8'h9A, 16'h1234, 8'h55, 1'b1, 1'b0, 1'b0);
    look("R1 path FF", 0, 8'hFF, 0, 8'hA1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_chan();
    hwr(0, 1, {2'd3, 8'd200}, 1'b1, 8'h33);
    hwr(0, 1, {2'd1, 8'd255}, 1'b1, 8'h66);
    look("R2 chan 3/200", 0, 3, 200, 8'h33, 1'b0, 1'b0, 1'b0);
    look("R2 chan 1/255", 0, 1, 255, 8'h66, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_range();
    hwr(0, 1, {2'd1, 8'd5}, 1'b1, 8'h77);
    hwr(0, 1, {2'd1, 8'd0}, 1'b1, 8'h12);
    look("R2 chan 1/5", 0, 1, 5, 8'h77, 1'b0, 1'b0, 1'b0);
    look("R3 vpi 5 alias", 0, 5, 5, 0, 1'b0, 1'b1, 1'b1);
    look("R4 vci 0x105 alias", 0, 1, 16'h105, 0, 1'b0, 1'b1, 1'b1);
    look("R4 vci 0", 0, 1, 0, 0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_invalid();
    look("R6 unwritten chan", 0, 2, 9, 0, 1'b0, 1'b1, 1'b0);
    hwr(0, 2, 8'h9B, 1'b1, 0);
    look("R6 unwritten path", 0, 8'h9B, 3, 0, 1'b1, 1'b1, 1'b0);
    hwr(0, 1, {2'd1, 8'd255}, 1'b0, 8'h66);
    look("R6 cleared entry", 0, 1, 255, 0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_ports();
    look("R5 port1 empty", 1, 3, 200, 0, 1'b0, 1'b1, 1'b0);
    hwr(1, 1, {2'd3, 8'd200}, 1'b1, 8'h44);
    look("R5 port1 own", 1, 3, 200, 8'h44, 1'b0, 1'b0, 1'b0);
    look("R5 port0 kept", 0, 3, 200, 8'h33, 1'b0, 1'b0, 1'b0);
    look("R5 port1 no path bit", 1, 8'h9A, 1, 0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_mode();
    hwr(0, 2, 8'h9A, 1'b0, 0);
    look("R7 path bit cleared", 0, 8'h9A, 10, 0, 1'b0, 1'b1, 1'b1);
    hwr(0, 2, 8'd3, 1'b1, 0);
    hwr(0, 0, 8'd3, 1'b1, 8'h21);
    look("R7 vpi 3 as path", 0, 3, 200, 8'h21, 1'b1, 1'b0, 1'b0);
    hwr(0, 2, 8'd3, 1'b0, 0);
    look("R7 vpi 3 back to chan", 0, 3, 200, 8'h33, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    host_we = 1'b1; host_port = 0; host_tbl = 2'd1;
    host_addr = {2'd3, 8'd200}; host_vld = 1'b1; host_idx = 8'hC3;
    in_valid = 1'b1; in_port = 0; in_vpi = 8'd3; in_vci = 16'd200;
    @(negedge clk);
    host_we = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk("R10 old contents valid", int'(out_valid), 1);
    chk("R10 old contents idx", int'(out_idx), 8'h33);
    look("R10 new contents", 0, 3, 200, 8'hC3, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_port = 0; in_vpi = 8'd1; in_vci = 16'd5;
    @(negedge clk);
    in_vpi = 8'd3; in_vci = 16'd200;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 first out valid", int'(out_valid), 1);
    chk("R9 first out idx", int'(out_idx), 8'h77);
    chk("R9 in_ready low", int'(in_ready), 0);
    repeat (3) @(negedge clk);
    chk("R9 held valid", int'(out_valid), 1);
    chk("R9 held idx", int'(out_idx), 8'h77);
    chk("R9 still blocked", int'(in_ready), 0);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9 second out valid", int'(out_valid), 1);
    chk("R9 second out idx", int'(out_idx), 8'hC3);
    @(negedge clk);
    chk("R9 drained", int'(out_valid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_port = '0; in_vpi = '0; in_vci = '0;
    out_ready = 1'b1; host_we = 1'b0; host_port = '0; host_tbl = '0;
    host_addr = '0; host_vld = 1'b0; host_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_path();
    t_chan();
    t_range();
    t_invalid();
    t_ports();
    t_mode();
    t_same_cycle();
    t_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule